// File: doc/BRIEF.md
# Programmable IR Carrier Synthesizer

This block divides the system oscillator clock down to an infrared remote-control carrier. A two-bit mode code, loaded through a one-cycle write port, selects the output. The output can be off. It can be one eighth of the clock with equal high and low times. It can be one twelfth of the clock with equal high and low times. It can also be one twelfth of the clock with the high time cut to a third of the period. With a 455 kHz oscillator the two carrier rates come to about 56.9 kHz and 37.9 kHz.

A single counter serves every mode. The counter wraps at the terminal count of the selected ratio. A comparison against the high length of the selected mode feeds a flip-flop, so the carrier pin never carries combinational glitches. A real change of mode clears the counter. The carrier then restarts with a fresh high phase, so no shortened pulse reaches the output.

Top module: `ir_carrier_synth`

## Requirements
- R1: While `rst` is sampled high on a clock edge, `carrierOut` is low after that edge, the mode returns to code 00 and a write presented in the same cycle is ignored.
- R2: Mode code 00 (carrier off, the value after reset) drives `carrierOut` low from the edge that loads it, and the output stays low for as long as that code is held.
- R3: Code 01 produces a period of 8 clocks: 4 high followed by 4 low, repeating.
- R4: Code 10 produces a period of 12 clocks: 6 high followed by 6 low, repeating.
- R5: Code 11 produces a period of 12 clocks: 4 high followed by 8 low, repeating.
- R6: A write of a code different from the current one drives `carrierOut` low after the write edge, whatever phase the old carrier was in. For a carrier mode, the first high clock of the new pattern follows on the next edge.
- R7: A write of the code already in force does not disturb the phase of the running carrier.
- R8: While `modeWe` is low, `modeIn` has no effect on the carrier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| modeWe | input | 1 | Write strobe for the mode code |
| modeIn | input | 2 | Mode code: 00 off, 01 divide by 8 half duty, 10 divide by 12 half duty, 11 divide by 12 third duty |
| carrierOut | output | 1 | Registered carrier output |

## Verification
The bench switches modes in the middle of a high phase, because a design that did not clear its counter would emit a shortened pulse or a stretched low phase. The same-code write is aimed at a design that restarts on every strobe, which would shift the carrier phase by one clock. A design whose comparison or terminal count is off by one is exposed by a full-period check in each of the three carrier modes, since the high time or the period would then be a clock too long or too short. A write applied together with reset, and a changing `modeIn` with the strobe low, catch designs that let the write path win or that ignore the strobe.

// File: rtl/ir_carrier_pkg.sv
package ir_carrier_pkg;

  typedef enum logic [1:0] {
    MODE_OFF        = 2'b00,
    MODE_FAST_HALF  = 2'b01,
    MODE_SLOW_HALF  = 2'b10,
    MODE_SLOW_THIRD = 2'b11
  } carrierMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic restart;   // clear counter and output this edge
    logic run;       // a carrier mode is in force
    logic selSlow;   // use the slow divide ratio
    logic selThird;  // use the one-third high length
  } carrierCtl_t;

endpackage

// File: rtl/ir_carrier_ctrl.sv
module ir_carrier_ctrl
  import ir_carrier_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        modeWe,
  input  logic [1:0]  modeIn,
  output carrierCtl_t ctl,
  output logic [1:0]  modeNow
);

  carrierMode_e modeReg;
  logic         writeHit;

  // Only a real change of code counts as a write
  assign writeHit = modeWe && (modeIn != modeReg);

  always_ff @(posedge clk) begin
    if (rst) begin
      modeReg <= MODE_OFF;
    end else if (writeHit) begin
      modeReg <= carrierMode_e'(modeIn);
    end
  end

  always_comb begin
    ctl.restart  = writeHit && !rst;
    ctl.run      = (modeReg != MODE_OFF);
    ctl.selSlow  = modeReg[1];
    ctl.selThird = (modeReg == MODE_SLOW_THIRD);
  end

  assign modeNow = modeReg;

endmodule

// File: rtl/ir_carrier_dp.sv
module ir_carrier_dp
  import ir_carrier_pkg::*;
#(
  parameter int DIV_FAST = 8,
  parameter int DIV_SLOW = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  carrierCtl_t ctl,
  output logic        carrierOut
);

  localparam int CNT_W           = $clog2(DIV_SLOW);
  localparam int HIGH_FAST       = DIV_FAST / 2;
  localparam int HIGH_SLOW_HALF  = DIV_SLOW / 2;
  localparam int HIGH_SLOW_THIRD = DIV_SLOW / 3;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastCnt;
  logic [CNT_W-1:0] highLen;
  logic             nextLevel;

  always_comb begin
    lastCnt = ctl.selSlow ? CNT_W'(DIV_SLOW - 1) : CNT_W'(DIV_FAST - 1);
    if (!ctl.selSlow)     highLen = CNT_W'(HIGH_FAST);
    else if (ctl.selThird) highLen = CNT_W'(HIGH_SLOW_THIRD);
    else                   highLen = CNT_W'(HIGH_SLOW_HALF);
    nextLevel = (cnt < highLen);
  end

  always_ff @(posedge clk) begin
    if (rst || ctl.restart || !ctl.run) begin
      cnt        <= '0;
      carrierOut <= 1'b0;
    end else begin
      carrierOut <= nextLevel;
      cnt        <= (cnt == lastCnt) ? '0 : cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/ir_carrier_synth.sv
module ir_carrier_synth
  import ir_carrier_pkg::*;
#(
  parameter int DIV_FAST = 8,
  parameter int DIV_SLOW = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       modeWe,
  input  logic [1:0] modeIn,
  output logic       carrierOut
);

  carrierCtl_t ctl;
  logic [1:0]  modeNow;

  ir_carrier_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .modeWe  (modeWe),
    .modeIn  (modeIn),
    .ctl     (ctl),
    .modeNow (modeNow)
  );

  ir_carrier_dp #(
    .DIV_FAST (DIV_FAST),
    .DIV_SLOW (DIV_SLOW)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .carrierOut (carrierOut)
  );

endmodule

// File: rtl/ir_carrier_synth_chk.sv
module ir_carrier_synth_chk #(
  parameter int DIV_FAST = 8,
  parameter int DIV_SLOW = 12
) (
  input logic       clk,
  input logic       rst,
  input logic       modeWe,
  input logic [1:0] modeIn,
  input logic [1:0] modeNow,
  input logic       carrierOut
);

  localparam int HF      = DIV_FAST / 2;
  localparam int HS      = DIV_SLOW / 2;
  localparam int MAX_HI  = (HF > HS) ? HF : HS;
  localparam int LF      = DIV_FAST - HF;
  localparam int LS      = DIV_SLOW - DIV_SLOW / 3;
  localparam int MAX_LO  = ((LF > LS) ? LF : LS) + 1;
  localparam int RUN_W   = $clog2(DIV_SLOW + 2) + 1;

  logic [RUN_W-1:0] highRun;
  logic [RUN_W-1:0] lowRun;

  always_ff @(posedge clk) begin
    if (rst) begin
      highRun <= '0;
      lowRun  <= '0;
    end else begin
      highRun <= carrierOut ? highRun + RUN_W'(1) : '0;
      lowRun  <= (!carrierOut && modeNow != 2'b00) ? lowRun + RUN_W'(1) : '0;
    end
  end

  // R1
  reset_low_chk: assert property (@(posedge clk) rst |=> !carrierOut);

  // R2
  off_low_chk: assert property (@(posedge clk) disable iff (rst)
    (modeNow == 2'b00) |-> !carrierOut);

  // R6
  restart_low_chk: assert property (@(posedge clk) disable iff (rst)
    (modeWe && modeIn != modeNow) |=> !carrierOut);

  // R8
  hold_mode_chk: assert property (@(posedge clk) disable iff (rst)
    !modeWe |=> $stable(modeNow));

  // R4
  high_run_chk: assert property (@(posedge clk) disable iff (rst)
    highRun <= RUN_W'(MAX_HI));

  // R5
  low_run_chk: assert property (@(posedge clk) disable iff (rst)
    lowRun <= RUN_W'(MAX_LO));

endmodule

bind ir_carrier_synth ir_carrier_synth_chk #(
  .DIV_FAST (DIV_FAST),
  .DIV_SLOW (DIV_SLOW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .modeWe     (modeWe),
  .modeIn     (modeIn),
  .modeNow    (modeNow),
  .carrierOut (carrierOut)
);

// File: tb/ir_carrier_synth_bench.sv
module ir_carrier_synth_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       modeWe = 1'b0;
  logic [1:0] modeIn = 2'b00;
  logic       carrierOut;

  int checks = 0;
  int fails  = 0;
  int phase  = 0;
  bit done   = 0;

  ir_carrier_synth u_ir_carrier_synth (
    .clk        (clk),
    .rst        (rst),
    .modeWe     (modeWe),
    .modeIn     (modeIn),
    .carrierOut (carrierOut)
  );

  always #10 clk = ~clk;

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: carrierOut=%b expected %b (phase %0d)", req, got, exp, phase);
    end
  endtask

  // One clock; expected level from the running phase
  task automatic step(input int period, input int high, input string req);
    @(negedge clk);
    check(carrierOut, ((phase % period) < high) ? 1'b1 : 1'b0, req);
    phase++;
  endtask

  task automatic writeMode(input logic [1:0] code, input bit isChange,
                           input int period, input int high, input string req);
    modeIn = code;
    modeWe = 1'b1;
    @(negedge clk);
    modeWe = 1'b0;
    if (isChange) begin
      check(carrierOut, 1'b0, req);
      phase = 0;
    end else begin
      check(carrierOut, ((phase % period) < high) ? 1'b1 : 1'b0, req);
      phase++;
    end
  endtask

  task automatic testReset();
    rst = 1'b1; modeIn = 2'b01; modeWe = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(carrierOut, 1'b0, "R1");
    end
    modeWe = 1'b0; rst = 1'b0;
    phase = 0;
    for (int i = 0; i < 10; i++) step(1, 0, "R1");   // write during reset ignored, still off
  endtask

  task automatic testFast();
    writeMode(2'b01, 1, 8, 4, "R3");
    for (int i = 0; i < 24; i++) step(8, 4, "R3");
  endtask

  task automatic testSameCode();
    for (int i = 0; i < 2; i++) step(8, 4, "R7");
    writeMode(2'b01, 0, 8, 4, "R7");
    for (int i = 0; i < 10; i++) step(8, 4, "R7");
  endtask

  task automatic testIgnore();
    modeIn = 2'b11;
    for (int i = 0; i < 6; i++) step(8, 4, "R8");
    modeIn = 2'b10;
    for (int i = 0; i < 6; i++) step(8, 4, "R8");
    modeIn = 2'b00;
    for (int i = 0; i < 6; i++) step(8, 4, "R8");
  endtask

  task automatic testSlowHalf();
    while ((phase % 8) != 1) step(8, 4, "R3");   // mid high phase
    writeMode(2'b10, 1, 12, 6, "R6");
    step(12, 6, "R6");                           // fresh high right after
    for (int i = 0; i < 35; i++) step(12, 6, "R4");
  endtask

  task automatic testThird();
    while ((phase % 12) != 8) step(12, 6, "R4"); // mid low phase
    writeMode(2'b11, 1, 12, 4, "R6");
    step(12, 4, "R6");
    for (int i = 0; i < 35; i++) step(12, 4, "R5");
  endtask

  task automatic testOff();
    while ((phase % 12) != 2) step(12, 4, "R5");
    writeMode(2'b00, 1, 1, 0, "R2");
    for (int i = 0; i < 20; i++) step(1, 0, "R2");
  endtask

  task automatic testResetMid();
    writeMode(2'b10, 1, 12, 6, "R6");
    for (int i = 0; i < 3; i++) step(12, 6, "R4");
    rst = 1'b1;
    @(negedge clk);
    check(carrierOut, 1'b0, "R1");
    rst = 1'b0;
    phase = 0;
    for (int i = 0; i < 14; i++) step(1, 0, "R1");  // back to off mode
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testFast();
    testSameCode();
    testIgnore();
    testSlowHalf();
    testThird();
    testOff();
    testResetMid();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule